// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits between the ECC encoder and the RAM array of a protected memory controller. It corrupts codewords on purpose so that the detection and correction logic downstream can be exercised. Every write presents a freshly encoded codeword (64 data bits and 8 check bits) together with a write strobe. One cycle later the block drives the word toward the array. Depending on a small control register, the word is unchanged, has one chosen bit inverted, or has the chosen bit and the overall odd-parity bit (index 71) both inverted. The check bits are never recomputed, so the corruption lands on a word that was encoded normally.

Three injection modes exist. Continuous single-bit mode corrupts every write. One-shot single-bit mode corrupts only the first write after it is armed. Continuous double mode produces an uncorrectable two-bit error on every write. The one-shot mode re-arms only on a 0-to-1 transition of its mode bit. The two single-bit mode bits can be turned on only while an external single-bit-reporting enable input is high.

Software writes the control register through a synchronous write-enable/data port and reads it back combinationally. The register holds three mode bits in [2:0] and a 7-bit position field in [14:8].

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset, wrOut is 0, codeOut is all zeros and ctlRdData is 0.
- R2: wrOut equals wrEn delayed by one clock. On a cycle with wrEn low, codeOut keeps its previous value and no injection state changes.
- R3: When ctlRdData[2:0] is 000, each written codeword appears unchanged on codeOut one cycle after its write strobe.
- R4: With bit 0 (continuous single) the highest active mode, every write inverts exactly codeword bit P, where P is ctlRdData[14:8]. A P of 72 or above inverts nothing.
- R5: With bit 1 (one-shot), only the first write after bit 1 goes from 0 to 1 inverts bit P. Later writes pass unchanged. Writing 1 to an already-set bit 1 does not re-arm it. Writing 0 and then 1 re-arms it.
- R6: With bit 2 (continuous double) set, every write inverts bit P and bit 71. A P of 71 inverts only bit 71. A P of 72 or above inverts nothing.
- R7: Priority is bit 2 over bit 0 over bit 1. A write that is outranked while the one-shot is armed does not consume the one-shot.
- R8: Bits 0 and 1 can change from 0 to 1 only while sbEnable is high. A bit that is already set stays set on a write of 1 while sbEnable is low. Writing 0 always clears it. Bit 2 and the position field are not gated.
- R9: A control write takes effect for data writes in the following cycles. A data write in the same cycle as a control write uses the old settings. ctlRdData returns {0, P, 00000, bit2, bit1, bit0}.
- R10: Idle cycles do not consume an armed one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbEnable | input | 1 | Permits the single-bit mode bits to be turned on |
| ctlWrEn | input | 1 | Control register write enable |
| ctlWrData | input | 16 | Control register write data |
| ctlRdData | output | 16 | Control register read-back |
| wrEn | input | 1 | Codeword write strobe |
| codeIn | input | 72 | Encoded codeword from the ECC encoder |
| wrOut | output | 1 | Delayed write strobe toward the RAM |
| codeOut | output | 72 | Possibly corrupted codeword toward the RAM |

## Verification
Two functions can fall in the same cycle: a control-register write and a data write. The bench provokes this by arming the one-shot in the same cycle as a data write. It checks that this write passes clean and that the next write is corrupted.

It also clears the one-shot bit in the same cycle as a write while the one-shot is armed. That write must still be corrupted, because it is judged against the settings in force before the control write.

A second overlap is a one-shot that is armed while a higher-priority mode owns a write. The bench confirms that the one-shot survives such writes and fires once the higher mode is dropped.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  localparam int CTL_W   = 16;
  localparam int POS_LSB = 8;
  localparam int POS_W   = 7;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_CONT = 2'd2,
    MODE_DBL  = 2'd3
  } injMode_t;

  typedef struct packed {
    logic             wrStb;
    logic             flipSel;
    logic             flipPar;
    logic [POS_W-1:0] pos;
  } injStrobe_t;

endpackage

// File: rtl/inj_control.sv
module inj_control
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sbEnable,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlRdData,
  input  logic             wrEn,
  output injStrobe_t       strobe
);

  logic             modeCont, modeOne, modeDbl, armed;
  logic [POS_W-1:0] pos;

  logic             modeContNext, modeOneNext, modeDblNext, armedNext;
  logic [POS_W-1:0] posNext;

  injMode_t         selMode;
  logic             posValid;
  logic             fireOne;

  // Pick the highest-priority mode that is active.
  always_comb begin
    if (modeDbl)               selMode = MODE_DBL;
    else if (modeCont)         selMode = MODE_CONT;
    else if (modeOne && armed) selMode = MODE_ONE;
    else                       selMode = MODE_PASS;
  end

  assign posValid = (int'(pos) < CW_W);
  assign fireOne  = wrEn && (selMode == MODE_ONE);

  always_comb begin
    strobe.wrStb   = wrEn;
    strobe.flipSel = wrEn && posValid && (selMode != MODE_PASS);
    strobe.flipPar = wrEn && posValid && (selMode == MODE_DBL);
    strobe.pos     = pos;
  end

  // Next register values. The single-bit modes can only rise while enabled.
  always_comb begin
    modeContNext = modeCont;
    modeOneNext  = modeOne;
    modeDblNext  = modeDbl;
    posNext      = pos;
    armedNext    = armed;
    if (fireOne) armedNext = 1'b0;
    if (ctlWrEn) begin
      modeContNext = ctlWrData[0] && (sbEnable || modeCont);
      modeOneNext  = ctlWrData[1] && (sbEnable || modeOne);
      modeDblNext  = ctlWrData[2];
      posNext      = ctlWrData[POS_LSB +: POS_W];
      if (!modeOneNext)  armedNext = 1'b0;
      else if (!modeOne) armedNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeCont <= 1'b0;
      modeOne  <= 1'b0;
      modeDbl  <= 1'b0;
      pos      <= '0;
      armed    <= 1'b0;
    end else begin
      modeCont <= modeContNext;
      modeOne  <= modeOneNext;
      modeDbl  <= modeDblNext;
      pos      <= posNext;
      armed    <= armedNext;
    end
  end

  always_comb begin
    ctlRdData                   = '0;
    ctlRdData[0]                = modeCont;
    ctlRdData[1]                = modeOne;
    ctlRdData[2]                = modeDbl;
    ctlRdData[POS_LSB +: POS_W] = pos;
  end

endmodule

// File: rtl/inj_datapath.sv
module inj_datapath
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  logic            clk,
  input  logic            rst,
  input  injStrobe_t      strobe,
  input  logic [CW_W-1:0] codeIn,
  output logic            wrOut,
  output logic [CW_W-1:0] codeOut
);

  localparam int PAR_IDX = CW_W - 1;

  logic [CW_W-1:0] flipMask;

  // One mask bit per codeword position.
  for (genvar i = 0; i < CW_W; i++) begin : g_mask
    if (i == PAR_IDX) begin : g_par
      assign flipMask[i] = strobe.flipPar ||
                           (strobe.flipSel && (int'(strobe.pos) == i));
    end else begin : g_dat
      assign flipMask[i] = strobe.flipSel && (int'(strobe.pos) == i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrOut   <= 1'b0;
      codeOut <= '0;
    end else begin
      wrOut <= strobe.wrStb;
      if (strobe.wrStb) codeOut <= codeIn ^ flipMask;
    end
  end

endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHECK_W = 8,
  localparam int CW_W   = DATA_W + CHECK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sbEnable,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlRdData,
  input  logic             wrEn,
  input  logic [CW_W-1:0]  codeIn,
  output logic             wrOut,
  output logic [CW_W-1:0]  codeOut
);

  injStrobe_t strobe;

  inj_control #(.CW_W(CW_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sbEnable  (sbEnable),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .ctlRdData (ctlRdData),
    .wrEn      (wrEn),
    .strobe    (strobe)
  );

  inj_datapath #(.CW_W(CW_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .codeIn  (codeIn),
    .wrOut   (wrOut),
    .codeOut (codeOut)
  );

endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int CW_W = 72
) (
  input logic            clk,
  input logic            rst,
  input logic            sbEnable,
  input logic            ctlWrEn,
  input logic [15:0]     ctlRdData,
  input logic            wrEn,
  input logic [CW_W-1:0] codeIn,
  input logic            wrOut,
  input logic [CW_W-1:0] codeOut
);

  logic posOk;
  assign posOk = (int'(ctlRdData[14:8]) < CW_W - 1);

  // R2
  wr_delay_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> wrOut);

  // R2
  wr_delay_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> !wrOut);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(codeOut));

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && ctlRdData[2:0] == 3'b000) |=> (codeOut == $past(codeIn)));

  // R4
  single_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && ctlRdData[2:0] == 3'b001 && posOk)
      |=> ($countones(codeOut ^ $past(codeIn)) == 1));

  // R6
  double_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && ctlRdData[2] && posOk)
      |=> ($countones(codeOut ^ $past(codeIn)) == 2));

  // R8
  cont_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!sbEnable && ctlWrEn && !ctlRdData[0]) |=> !ctlRdData[0]);

  // R8
  one_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!sbEnable && ctlWrEn && !ctlRdData[1]) |=> !ctlRdData[1]);

endmodule

bind ecc_fault_injector inj_checker #(.CW_W(CW_W)) chk_i (.*);

// File: tb/ecc_fault_injector_tb.sv
module ecc_fault_injector_tb_top;

  localparam int CW = 72;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sbEnable = 1'b1;
  logic          ctlWrEn = 1'b0;
  logic [15:0]   ctlWrData = '0;
  logic [15:0]   ctlRdData;
  logic          wrEn = 1'b0;
  logic [CW-1:0] codeIn = '0;
  logic          wrOut;
  logic [CW-1:0] codeOut;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  ecc_fault_injector dut_i (
    .clk(clk), .rst(rst), .sbEnable(sbEnable),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .wrEn(wrEn), .codeIn(codeIn), .wrOut(wrOut), .codeOut(codeOut)
  );

  function automatic logic [CW-1:0] pat(int i);
    logic [CW-1:0] v;
    v = CW'(i + 1) * 72'h9E3779B97F4A7C15;
    return v ^ {v[35:0], v[71:36]};
  endfunction

  function automatic logic [CW-1:0] bitMask(int p);
    if (p < CW) return CW'(1) << p;
    return '0;
  endfunction

  function automatic logic [CW-1:0] dblMask(int p);
    if (p < CW) return bitMask(p) | bitMask(CW - 1);
    return '0;
  endfunction

  function automatic logic [15:0] ctlWord(int p, logic [2:0] m);
    return {1'b0, 7'(p), 5'b0, m};
  endfunction

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctlWr(logic [15:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic dataWr(string req, logic [CW-1:0] c, logic [CW-1:0] m);
    @(negedge clk);
    wrEn = 1'b1;
    codeIn = c;
    @(negedge clk);
    wrEn = 1'b0;
    chk(req, CW'(wrOut), CW'(1'b1));
    chk(req, codeOut, c ^ m);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    logic [CW-1:0] last;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", CW'(wrOut), '0);
    chk("R1", codeOut, '0);
    chk("R1", CW'(ctlRdData), '0);

    // R3 pass through, several patterns
    for (int i = 0; i < 16; i++) dataWr("R3", pat(i), '0);

    // R4 continuous single, every position value
    for (int p = 0; p < 128; p++) begin
      ctlWr(ctlWord(p, 3'b001));
      chk("R9", CW'(ctlRdData), CW'(ctlWord(p, 3'b001)));
      dataWr("R4", pat(p), bitMask(p));
      dataWr("R4", pat(p + 300), bitMask(p));
    end

    // R6 continuous double, every position value
    for (int p = 0; p < 128; p++) begin
      ctlWr(ctlWord(p, 3'b100));
      dataWr("R6", pat(p + 500), dblMask(p));
      dataWr("R6", pat(p + 700), dblMask(p));
    end

    // R5 one-shot
    for (int p = 0; p < CW; p += 7) begin
      ctlWr(ctlWord(p, 3'b000));
      ctlWr(ctlWord(p, 3'b010));
      dataWr("R5", pat(p), bitMask(p));
      dataWr("R5", pat(p + 1), '0);
      ctlWr(ctlWord(p, 3'b010));   // rewrite of 1: no re-arm
      dataWr("R5", pat(p + 2), '0);
      ctlWr(ctlWord(p, 3'b000));
      ctlWr(ctlWord(p, 3'b010));   // 0 then 1: re-armed
      dataWr("R5", pat(p + 3), bitMask(p));
      dataWr("R5", pat(p + 4), '0);
    end

    // R10 idle cycles leave the one-shot armed and the output held
    ctlWr(ctlWord(9, 3'b000));
    ctlWr(ctlWord(9, 3'b010));
    dataWr("R10", pat(41), '0 | bitMask(9));
    last = codeOut;
    ctlWr(ctlWord(9, 3'b000));
    ctlWr(ctlWord(9, 3'b010));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      codeIn = pat(k + 900);
      chk("R2", CW'(wrOut), '0);
      chk("R2", codeOut, last);
    end
    dataWr("R10", pat(42), bitMask(9));

    // R7 priority
    ctlWr(ctlWord(20, 3'b000));
    ctlWr(ctlWord(20, 3'b111));
    dataWr("R7", pat(50), dblMask(20));
    ctlWr(ctlWord(20, 3'b011));
    dataWr("R7", pat(51), bitMask(20));
    dataWr("R7", pat(52), bitMask(20));
    ctlWr(ctlWord(20, 3'b010));    // bit1 held: one-shot still armed
    dataWr("R7", pat(53), bitMask(20));
    dataWr("R7", pat(54), '0);

    // R9 same-cycle control and data write
    ctlWr(ctlWord(33, 3'b000));
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = ctlWord(33, 3'b010);
    wrEn = 1'b1; codeIn = pat(60);
    @(negedge clk);
    ctlWrEn = 1'b0; wrEn = 1'b0;
    chk("R9", codeOut, pat(60));
    dataWr("R9", pat(61), bitMask(33));
    ctlWr(ctlWord(33, 3'b000));
    ctlWr(ctlWord(33, 3'b010));
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = ctlWord(33, 3'b000);
    wrEn = 1'b1; codeIn = pat(62);
    @(negedge clk);
    ctlWrEn = 1'b0; wrEn = 1'b0;
    chk("R9", codeOut, pat(62) ^ bitMask(33));

    // R8 enable gating
    ctlWr(ctlWord(0, 3'b000));
    sbEnable = 1'b0;
    ctlWr(ctlWord(12, 3'b011));
    chk("R8", CW'(ctlRdData), CW'(ctlWord(12, 3'b000)));
    dataWr("R8", pat(70), '0);
    ctlWr(ctlWord(12, 3'b100));
    chk("R8", CW'(ctlRdData), CW'(ctlWord(12, 3'b100)));
    sbEnable = 1'b1;
    ctlWr(ctlWord(12, 3'b001));
    sbEnable = 1'b0;
    ctlWr(ctlWord(12, 3'b001));
    chk("R8", CW'(ctlRdData), CW'(ctlWord(12, 3'b001)));
    dataWr("R8", pat(71), bitMask(12));
    ctlWr(ctlWord(12, 3'b000));
    chk("R8", CW'(ctlRdData), CW'(ctlWord(12, 3'b000)));
    sbEnable = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule